// File: doc/BRIEF.md
# Periodic Digital Clock Calibration Unit

This block sits in a real-time clock's divider chain. It counts a 32768 Hz oscillator tick, given as a single-cycle enable in the system clock domain, and produces a one-cycle enable once per second. The chain has two stages. The first stage divides by 256 and the second by 128.

A 5-bit magnitude and a direction bit trim the average rate. Trimming works by changing the length of chosen seconds over a repeating window of 64 minutes:
- **Fast direction:** one first-stage period is cut in half. That second loses 128 ticks.
- **Slow direction:** one first-stage period is dropped from the second stage. That second gains 256 ticks.

Only second 0 of a minute is ever changed. It is changed only in the first 2×N minutes of the window, where N is the magnitude. When N is 0, every second lasts exactly 32768 ticks. The magnitude and direction are captured at each minute boundary and also during reset. A change in the middle of a minute therefore takes effect at the next minute.

The block also outputs a minute-boundary pulse and the current minute position inside the window. These let a test reach the trimmed seconds quickly.

Top module: `rtc_rate_trim`

## Requirements
- R1: With a captured magnitude of 0, every second lasts exactly PRE_DIV×POST_DIV ticks (32768 by default), whatever the direction bit.
- R2: A trimmed second with trim_fast=1 lasts PRE_DIV×POST_DIV − PRE_DIV/2 ticks (32640 by default).
- R3: A trimmed second with trim_fast=0 lasts PRE_DIV×POST_DIV + PRE_DIV ticks (33024 by default).
- R4: Only second 0 of a minute can be trimmed. Every other second has the nominal length.
- R5: With captured magnitude N > 0, the minutes whose window index is below 2×N are trimmed. Every other minute is nominal. If 2×N reaches CYCLE_MIN, every minute is trimmed.
- R6: cycle_min counts minutes from 0 to CYCLE_MIN−1 and then wraps to 0. It advances in the same cycle that min_pulse is high. min_pulse is high only together with sec_pulse, on the end of second SECS_PER_MIN−1.
- R7: trim_mag and trim_fast are captured while rst is high and at each minute boundary. Changes at other times have no effect until the next boundary.
- R8: During and right after synchronous reset, sec_pulse and min_pulse are 0, cycle_min is 0, and the tick count restarts at zero.
- R9: Only cycles with tick_en=1 are counted. sec_pulse is high for exactly one cycle, in the cycle after the tick that ends a second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle oscillator tick enable |
| trim_mag | input | 5 | Trim magnitude N (0..31) |
| trim_fast | input | 1 | Direction: 1 shortens trimmed seconds, 0 lengthens them |
| sec_pulse | output | 1 | One-cycle enable at the end of each second |
| min_pulse | output | 1 | One-cycle enable at the end of each minute |
| cycle_min | output | $clog2(CYCLE_MIN) | Minute index inside the trim window |

## Verification
The assertions assume the following about the inputs:
- tick_en is a clean single-cycle enable with no relation to second boundaries.
- trim_mag and trim_fast may change in any cycle.
- The divider parameters satisfy PRE_DIV even and POST_DIV ≥ 2.

Under those assumptions, the assertions check that the trim mode never changes inside a second and that the captured setting never changes between minute boundaries.

The stimulus uses small divider parameters so that whole 8-minute windows fit in a short run. It mixes continuous ticks with sparse, irregular tick patterns. It changes the trim setting only through the ports, including in the middle of minutes. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int MAG_W = 5;

    typedef enum logic [1:0] {
        TRIM_NONE = 2'd0,
        TRIM_FAST = 2'd1,
        TRIM_SLOW = 2'd2
    } trim_mode_e;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             fast;
    } trim_cfg_t;

    // Mode for second 0 of a given minute index under a captured setting.
    function automatic trim_mode_e pick_mode(input int unsigned min_idx,
                                             input trim_cfg_t    cfg);
        int unsigned span;
        span = 2 * 32'(cfg.mag);
        if (cfg.mag != '0 && min_idx < span)
            return cfg.fast ? TRIM_FAST : TRIM_SLOW;
        return TRIM_NONE;
    endfunction

endpackage

// File: rtl/trim_prescaler.sv
module trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int PRE_DIV = 256,
    localparam int P_W    = $clog2(PRE_DIV)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  trim_mode_e mode,
    input  logic       first_period,
    output logic       stage_end
);

    logic [P_W-1:0] cnt;
    logic [P_W-1:0] term;

    // In a fast-trimmed second the first stage period is halved.
    always_comb begin
        if (mode == TRIM_FAST && first_period)
            term = P_W'(PRE_DIV / 2 - 1);
        else
            term = P_W'(PRE_DIV - 1);
    end

    assign stage_end = tick_en && (cnt == term);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick_en)
            cnt <= stage_end ? '0 : cnt + 1'b1;
    end

    // Every tick that does not end a stage period advances the count.
    p_tick_counted_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !stage_end) |=> cnt == $past(cnt) + 1'b1);

    // Without a tick the count holds.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

endmodule

// File: rtl/trim_second_div.sv
module trim_second_div
    import rtc_trim_pkg::*;
#(
    parameter int POST_DIV = 128,
    localparam int Q_W     = $clog2(POST_DIV + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stage_end,
    input  trim_mode_e mode,
    output logic       first_period,
    output logic       sec_end
);

    logic [Q_W-1:0] cnt;
    logic [Q_W-1:0] term;

    // A slow-trimmed second swallows one extra stage period.
    always_comb begin
        if (mode == TRIM_SLOW)
            term = Q_W'(POST_DIV);
        else
            term = Q_W'(POST_DIV - 1);
    end

    assign first_period = (cnt == '0);
    assign sec_end      = stage_end && (cnt == term);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (stage_end)
            cnt <= (cnt == term) ? '0 : cnt + 1'b1;
    end

    // The extra count position is reached only in a slow-trimmed second.
    p_extra_slow_only_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == Q_W'(POST_DIV)) |-> mode == TRIM_SLOW);

endmodule

// File: rtl/trim_minute_seq.sv
module trim_minute_seq
    import rtc_trim_pkg::*;
#(
    parameter int SECS_PER_MIN = 60,
    parameter int CYCLE_MIN    = 64,
    localparam int S_W         = $clog2(SECS_PER_MIN),
    localparam int C_W         = $clog2(CYCLE_MIN)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sec_end,
    input  trim_cfg_t      cfg_in,
    output trim_mode_e     mode,
    output logic           min_end,
    output logic [C_W-1:0] min_idx
);

    logic [S_W-1:0] sec_idx;
    trim_cfg_t      cfg_q;

    assign min_end = sec_end && (sec_idx == S_W'(SECS_PER_MIN - 1));

    always_comb begin
        if (sec_idx == '0)
            mode = pick_mode(32'(min_idx), cfg_q);
        else
            mode = TRIM_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_idx <= '0;
            min_idx <= '0;
            cfg_q   <= cfg_in;
        end else if (sec_end) begin
            if (min_end) begin
                sec_idx <= '0;
                min_idx <= (min_idx == C_W'(CYCLE_MIN - 1)) ? '0 : min_idx + 1'b1;
                cfg_q   <= cfg_in;
            end else begin
                sec_idx <= sec_idx + 1'b1;
            end
        end
    end

    // Captured setting changes only at a minute boundary.
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !min_end |=> $stable(cfg_q));

    // Minute index changes only at a minute boundary.
    p_min_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !min_end |=> $stable(min_idx));

    // Minute index stays inside the window.
    p_min_range_r6: assert property (@(posedge clk) disable iff (rst)
        32'(min_idx) < CYCLE_MIN);

endmodule

// File: rtl/rtc_rate_trim.sv
module rtc_rate_trim
    import rtc_trim_pkg::*;
#(
    parameter int PRE_DIV      = 256,
    parameter int POST_DIV     = 128,
    parameter int SECS_PER_MIN = 60,
    parameter int CYCLE_MIN    = 64,
    localparam int C_W         = $clog2(CYCLE_MIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [MAG_W-1:0] trim_mag,
    input  logic             trim_fast,
    output logic             sec_pulse,
    output logic             min_pulse,
    output logic [C_W-1:0]   cycle_min
);

    trim_cfg_t  cfg_in;
    trim_mode_e mode;
    logic       stage_end;
    logic       first_period;
    logic       sec_end;
    logic       min_end;

    assign cfg_in = '{mag: trim_mag, fast: trim_fast};

    trim_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .mode         (mode),
        .first_period (first_period),
        .stage_end    (stage_end)
    );

    trim_second_div #(.POST_DIV(POST_DIV)) u_sec (
        .clk          (clk),
        .rst          (rst),
        .stage_end    (stage_end),
        .mode         (mode),
        .first_period (first_period),
        .sec_end      (sec_end)
    );

    trim_minute_seq #(
        .SECS_PER_MIN (SECS_PER_MIN),
        .CYCLE_MIN    (CYCLE_MIN)
    ) u_min (
        .clk     (clk),
        .rst     (rst),
        .sec_end (sec_end),
        .cfg_in  (cfg_in),
        .mode    (mode),
        .min_end (min_end),
        .min_idx (cycle_min)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_pulse <= 1'b0;
            min_pulse <= 1'b0;
        end else begin
            sec_pulse <= sec_end;
            min_pulse <= min_end;
        end
    end

    p_min_with_sec_r6: assert property (@(posedge clk) disable iff (rst)
        min_pulse |-> sec_pulse);

    p_pulse_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> $past(tick_en));

    // The trim mode is fixed for the whole of a second.
    p_mode_steady_r4: assert property (@(posedge clk) disable iff (rst)
        !sec_end |=> $stable(mode));

endmodule

// File: tb/rtc_rate_trim_tb.sv
module rtc_rate_trim_tb;

    localparam int PRE  = 8;
    localparam int POST = 4;
    localparam int SECS = 4;
    localparam int CYC  = 8;
    localparam int NOM  = PRE * POST;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [4:0] trim_mag = '0;
    logic       trim_fast = 1'b0;
    logic       sec_pulse, min_pulse;
    logic [2:0] cycle_min;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R8";
    int    tick_mode = 0;   // 0: every cycle, 1: sparse irregular

    always #10 clk = ~clk;

    rtc_rate_trim #(
        .PRE_DIV(PRE), .POST_DIV(POST), .SECS_PER_MIN(SECS), .CYCLE_MIN(CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .trim_mag(trim_mag), .trim_fast(trim_fast),
        .sec_pulse(sec_pulse), .min_pulse(min_pulse), .cycle_min(cycle_min)
    );

    // Behavioural reference: tick count against expected second length.
    int t_cnt, sec_no, min_no, mag_l;
    bit sgn_l, e_sec, e_min;
    int e_cyc;

    function automatic int sec_len();
        if (sec_no == 0 && mag_l != 0 && min_no < 2 * mag_l)
            return sgn_l ? NOM - PRE / 2 : NOM + PRE;
        return NOM;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            t_cnt = 0; sec_no = 0; min_no = 0;
            mag_l = int'(trim_mag); sgn_l = trim_fast;
            e_sec = 0; e_min = 0;
        end else begin
            e_sec = 0; e_min = 0;
            if (tick_en) begin
                t_cnt++;
                if (t_cnt == sec_len()) begin
                    t_cnt = 0; e_sec = 1; sec_no++;
                    if (sec_no == SECS) begin
                        sec_no = 0; e_min = 1;
                        min_no = (min_no + 1) % CYC;
                        mag_l = int'(trim_mag); sgn_l = trim_fast;
                    end
                end
            end
        end
        e_cyc = min_no;
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t",
                     cur_req, what, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check("sec_pulse", int'(sec_pulse), int'(e_sec));
            check("min_pulse", int'(min_pulse), int'(e_min));
            check("cycle_min", int'(cycle_min), e_cyc);
        end
    end

    // Tick generator.
    int lfsr = 32'h1d5;
    always @(negedge clk) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
        if (rst) tick_en <= 1'b0;
        else if (tick_mode == 0) tick_en <= 1'b1;
        else tick_en <= (lfsr % 3) == 0;
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [4:0] m, input logic s);
        @(negedge clk);
        rst = 1'b1; trim_mag = m; trim_fast = s;
        run(3);
        // R8: reset state
        cur_req = "R8";
        check("sec_pulse in reset", int'(sec_pulse), 0);
        check("min_pulse in reset", int'(min_pulse), 0);
        check("cycle_min in reset", int'(cycle_min), 0);
        rst = 1'b0;
    endtask

    localparam int WIN = CYC * SECS * (NOM + PRE) + 64;

    initial begin
        // R1: magnitude 0, both directions
        do_reset(5'd0, 1'b1);
        cur_req = "R1"; tick_mode = 0; run(WIN);
        trim_fast = 1'b0; run(WIN);
        // R2 and R5: fast trim, N=1 -> minutes 0,1 trimmed
        do_reset(5'd1, 1'b1);
        cur_req = "R2"; run(2 * WIN);
        // R3 and R4: slow trim, N=2 -> minutes 0..3, second 0 only
        do_reset(5'd2, 1'b0);
        cur_req = "R3"; run(2 * WIN);
        // R5: magnitude large enough to cover every minute
        do_reset(5'd31, 1'b0);
        cur_req = "R5"; run(WIN);
        // R9: sparse irregular ticks with fast trim
        do_reset(5'd3, 1'b1);
        cur_req = "R9"; tick_mode = 1; run(3 * WIN);
        // R7: setting changes in mid-minute; R6 wrap observed throughout
        tick_mode = 0; cur_req = "R7";
        for (int i = 0; i < 40; i++) begin
            run(37 + 11 * (i % 5));
            trim_mag  = 5'((i * 7) % 6);
            trim_fast = i[0];
        end
        cur_req = "R6"; run(2 * WIN);
        // R4: explicit look at a non-zero second staying nominal is part of the model
        cur_req = "R4"; trim_mag = 5'd4; trim_fast = 1'b1; run(WIN);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule